// File: doc/BRIEF.md
# Acquisition Sample Buffer with Overflow Capture

This block sits between an analog-to-digital converter and whatever drains its results, such as a host read path or a DMA requester. Each time the timing logic reports that a conversion has finished, the block stores the 16-bit result. A reader can then remove the stored results in arrival order at its own pace. Because the converter never waits on the reader, a conversion that finishes while the buffer is full is discarded. That loss is latched as a sticky error, which stays set until a clear input removes it.

The configuration sequencer can mark a conversion as a "ghost". A ghost conversion still happens on the analog side, but its result is never stored and it can never count as an overflow. Three occupancy flags (not-empty, half-full and full) are exported so that surrounding logic can raise interrupts or DMA requests. The read data comes from a register. A pop loads it with the oldest stored sample, and it holds that value until the next successful pop.

Top module: `acq_fifo`

## Requirements
- R1: After reset, not_empty_o, half_full_o, full_o and ovf_err_o are 0 and rd_data_o is 0.
- R2: A cycle with conv_done_i=1 and ghost_i=0 while full_o=0 stores sample_i, and not_empty_o reads 1 after that clock edge.
- R3: A cycle with rd_en_i=1 while not_empty_o=1 loads rd_data_o, after that edge, with the oldest stored sample. Samples leave in the order they were stored.
- R4: A cycle with conv_done_i=1 and ghost_i=1 stores nothing and never sets ovf_err_o.
- R5: half_full_o is 1 exactly when the occupancy is at least DEPTH/2. With the default depth of 512, that means 256 or more.
- R6: full_o is 1 exactly when the occupancy equals DEPTH.
- R7: A non-ghost conversion in a cycle where full_o=1 is dropped, and ovf_err_o reads 1 after that edge. The stored contents are unchanged. This holds even if a read happens in the same cycle.
- R8: ovf_err_o stays 1 until a cycle with ovf_clr_i=1 and no new overflow. After that cycle it reads 0. If a clear and an overflow fall in the same cycle, the overflow wins.
- R9: rd_en_i=1 while not_empty_o=0 leaves rd_data_o unchanged and removes nothing.
- R10: A read and a non-ghost conversion in the same cycle, when the buffer is neither empty nor full, keep the occupancy unchanged and preserve the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_done_i | input | 1 | Conversion-complete strobe, one sample per high cycle |
| ghost_i | input | 1 | Marks the current conversion as not to be stored |
| sample_i | input | 16 | Converter result |
| rd_en_i | input | 1 | Pop request from the reader |
| ovf_clr_i | input | 1 | Clears the sticky overflow error |
| rd_data_o | output | 16 | Most recently popped sample |
| not_empty_o | output | 1 | Buffer holds at least one sample |
| half_full_o | output | 1 | Occupancy at least half the depth |
| full_o | output | 1 | Occupancy equals the depth |
| ovf_err_o | output | 1 | Sticky overflow error |

## Verification
The bench uses several stimulus patterns, each aimed at a different class of fault:

- Plain push then pop with distinct values exposes pointer or ordering faults.
- Interleaved ghost and real conversions show whether the ghost qualifier blocks the write and still lets real samples through.
- A fill sweep across DEPTH/2-1, DEPTH/2, DEPTH-1 and DEPTH separates off-by-one faults in the half-full and full thresholds.
- Overflow attempts alone, with a same-cycle read, and with a same-cycle clear, followed by a full drain, distinguish a dropped sample from an overwritten one, and a sticky error from a transient one.

// File: rtl/acq_fifo_pkg.sv
package acq_fifo_pkg;

  // Operation applied to the occupancy in one cycle
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } fifo_op_e;

endpackage

// File: rtl/acq_fifo_rstsync.sv
module acq_fifo_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/acq_fifo_ptrs.sv
module acq_fifo_ptrs
  import acq_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count
);

  logic [AW-1:0] wptr_q, wptr_d;
  logic [AW-1:0] rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          is_full, is_empty;
  fifo_op_e      op;

  assign is_full  = (cnt_q == CW'(DEPTH));
  assign is_empty = (cnt_q == '0);
  assign push_ok  = push_req && !is_full;
  assign pop_ok   = pop_req && !is_empty;
  assign op       = fifo_op_e'({pop_ok, push_ok});

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (push_ok) wptr_d = wptr_q + AW'(1);
    if (pop_ok)  rptr_d = rptr_q + AW'(1);
    case (op)
      OP_PUSH: cnt_d = cnt_q + CW'(1);
      OP_POP:  cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign count = cnt_q;

endmodule

// File: rtl/acq_fifo_mem.sv
module acq_fifo_mem #(
  parameter int DW = 16,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] store_q [DEPTH];
  logic [DW-1:0] out_q, out_d;

  // Storage array: no reset, written only on accepted pushes
  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    out_d = out_q;
    if (rd_en) out_d = store_q[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

  assign rd_data = out_q;

endmodule

// File: rtl/acq_fifo_flags.sv
module acq_fifo_flags #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1,
  localparam int HALF_AT = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          push_req,
  input  logic          ovf_clr,
  output logic          not_empty,
  output logic          half_full,
  output logic          full,
  output logic          ovf_err
);

  logic ovf_q, ovf_d;
  logic ovf_hit;

  assign not_empty = (count != '0);
  assign full      = (count == CW'(DEPTH));

  generate
    if (HALF_AT <= 1) begin : g_half_tiny
      assign half_full = not_empty;
    end else begin : g_half_cmp
      assign half_full = (count >= CW'(HALF_AT));
    end
  endgenerate

  // A real sample arriving while full is lost; set takes priority over clear
  assign ovf_hit = push_req && full;

  always_comb begin
    ovf_d = ovf_q;
    if (ovf_hit)      ovf_d = 1'b1;
    else if (ovf_clr) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign ovf_err = ovf_q;

endmodule

// File: rtl/acq_fifo.sv
module acq_fifo #(
  parameter int DW = 16,
  parameter int DEPTH = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          conv_done_i,
  input  logic          ghost_i,
  input  logic [DW-1:0] sample_i,
  input  logic          rd_en_i,
  input  logic          ovf_clr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          not_empty_o,
  output logic          half_full_o,
  output logic          full_o,
  output logic          ovf_err_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          rst_sync_n;
  logic          push_req;
  logic          push_ok, pop_ok;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  assign push_req = conv_done_i && !ghost_i;

  acq_fifo_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk         (clk_i),
    .rst_n_async (rst_n_i),
    .rst_n_sync  (rst_sync_n)
  );

  acq_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk_i),
    .rst_n    (rst_sync_n),
    .push_req (push_req),
    .pop_req  (rd_en_i),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .wptr     (wptr),
    .rptr     (rptr),
    .count    (count)
  );

  acq_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk     (clk_i),
    .rst_n   (rst_sync_n),
    .wr_en   (push_ok),
    .wr_addr (wptr),
    .wr_data (sample_i),
    .rd_en   (pop_ok),
    .rd_addr (rptr),
    .rd_data (rd_data_o)
  );

  acq_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk_i),
    .rst_n     (rst_sync_n),
    .count     (count),
    .push_req  (push_req),
    .ovf_clr   (ovf_clr_i),
    .not_empty (not_empty_o),
    .half_full (half_full_o),
    .full      (full_o),
    .ovf_err   (ovf_err_o)
  );

endmodule

// File: rtl/acq_fifo_chk.sv
module acq_fifo_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_done_i,
  input logic          ghost_i,
  input logic          rd_en_i,
  input logic          ovf_clr_i,
  input logic [DW-1:0] rd_data_o,
  input logic          not_empty_o,
  input logic          half_full_o,
  input logic          full_o,
  input logic          ovf_err_o
);

  // R2: a real sample into an empty buffer makes it non-empty
  a_r2_push_sets_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_i && !ghost_i && !not_empty_o) |=> not_empty_o);

  // R4: a ghost conversion into an empty buffer with no read leaves it empty
  a_r4_ghost_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done_i && ghost_i && !not_empty_o) |=> !not_empty_o);

  // R4: ghost never raises the error
  a_r4_ghost_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_err_o && conv_done_i && ghost_i && !ovf_clr_i) |=> !ovf_err_o);

  // R5/R6: full implies half-full and not-empty
  a_r6_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> (half_full_o && not_empty_o));

  // R7: real sample while full raises the error
  a_r7_overflow_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && conv_done_i && !ghost_i) |=> ovf_err_o);

  // R8: sticky until cleared
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_err_o && !ovf_clr_i) |=> ovf_err_o);

  // R8: clear without a new overflow drops the error
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr_i && !(full_o && conv_done_i && !ghost_i)) |=> !ovf_err_o);

  // R9: read of an empty buffer holds the output
  a_r9_empty_read_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !not_empty_o) |=> $stable(rd_data_o));

  // R3: without a read the output never changes
  a_r3_no_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i) |=> $stable(rd_data_o));

endmodule

bind acq_fifo acq_fifo_chk #(.DW(DW)) u_chk (
  .clk         (clk_i),
  .rst_n       (rst_sync_n),
  .conv_done_i (conv_done_i),
  .ghost_i     (ghost_i),
  .rd_en_i     (rd_en_i),
  .ovf_clr_i   (ovf_clr_i),
  .rd_data_o   (rd_data_o),
  .not_empty_o (not_empty_o),
  .half_full_o (half_full_o),
  .full_o      (full_o),
  .ovf_err_o   (ovf_err_o)
);

// File: tb/acq_fifo_tb.sv
`timescale 1ns/1ps
module acq_fifo_tb;

  localparam int DW = 16;
  localparam int DEPTH = 512;

  logic          clk;
  logic          rst_n;
  logic          conv, ghost, rd, clr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          ne, hf, fu, ovf;

  int nchk = 0;
  int nfail = 0;

  // Reference model state
  logic [DW-1:0] mq [$];
  logic          m_ovf;
  logic [DW-1:0] m_out;

  acq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .conv_done_i (conv),
    .ghost_i     (ghost),
    .sample_i    (din),
    .rd_en_i     (rd),
    .ovf_clr_i   (clr),
    .rd_data_o   (dout),
    .not_empty_o (ne),
    .half_full_o (hf),
    .full_o      (fu),
    .ovf_err_o   (ovf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare all outputs against the model
  task automatic chk_all(string req);
    int n = mq.size();
    chk(req, "rd_data", 32'(dout), 32'(m_out));
    chk(req, "not_empty", 32'(ne), 32'(n != 0));
    chk(req, "half_full", 32'(hf), 32'(n >= DEPTH/2));
    chk(req, "full", 32'(fu), 32'(n == DEPTH));
    chk(req, "ovf_err", 32'(ovf), 32'(m_ovf));
  endtask

  // One cycle of stimulus, applied at a falling edge; model updated alongside
  task automatic step(logic c, logic g, logic [DW-1:0] d, logic r, logic k);
    bit was_full = (mq.size() == DEPTH);
    bit was_empty = (mq.size() == 0);
    conv = c; ghost = g; din = d; rd = r; clr = k;
    if (r && !was_empty) m_out = mq.pop_front();
    if (c && !g) begin
      if (was_full) m_ovf = 1'b1;
      else mq.push_back(d);
    end else if (k) m_ovf = 1'b0;
    if (c && !g && was_full) m_ovf = 1'b1;
    else if (k) m_ovf = 1'b0;
    @(negedge clk);
    conv = 0; ghost = 0; rd = 0; clr = 0;
  endtask

  task automatic drain(string req);
    while (mq.size() != 0) begin
      step(0, 0, '0, 1, 0);
      chk(req, "drain data", 32'(dout), 32'(m_out));
    end
    chk_all(req);
  endtask

  task automatic t_reset();
    chk_all("R1");
    chk("R1", "rd_data zero", 32'(dout), 32'h0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) begin
      step(1, 0, 16'h1100 + 16'(i), 0, 0);
      chk_all("R2");
    end
    for (int i = 0; i < 5; i++) begin
      step(0, 0, '0, 1, 0);
      chk("R3", "order", 32'(dout), 32'(16'h1100 + 16'(i)));
      chk_all("R3");
    end
  endtask

  task automatic t_ghost();
    step(1, 1, 16'hDEAD, 0, 0);
    chk_all("R4");
    step(1, 0, 16'h2001, 0, 0);
    step(1, 1, 16'hBEEF, 0, 0);
    step(1, 0, 16'h2002, 0, 0);
    chk_all("R4");
    step(0, 0, '0, 1, 0);
    chk("R4", "first real", 32'(dout), 32'h2001);
    step(0, 0, '0, 1, 0);
    chk("R4", "second real", 32'(dout), 32'h2002);
    chk_all("R4");
  endtask

  task automatic t_empty_read();
    logic [DW-1:0] held = dout;
    step(0, 0, '0, 1, 0);
    chk("R9", "hold", 32'(dout), 32'(held));
    chk_all("R9");
    step(1, 0, 16'h3003, 0, 0);
    step(0, 0, '0, 1, 0);
    chk("R9", "no phantom pop", 32'(dout), 32'h3003);
    chk_all("R9");
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      step(1, 0, 16'h4000 + 16'(i), 0, 0);
      if (i + 1 == DEPTH/2 - 1 || i + 1 == DEPTH/2) chk_all("R5");
      if (i + 1 == DEPTH - 1 || i + 1 == DEPTH) chk_all("R6");
    end
  endtask

  task automatic t_overflow();
    step(1, 0, 16'hF00D, 0, 0);
    chk_all("R7");
    step(0, 0, '0, 0, 0);
    chk_all("R8");
    step(1, 0, 16'hF00E, 1, 0);
    chk_all("R7");
    step(1, 0, 16'h5000, 0, 0);
    chk_all("R7");
    step(1, 0, 16'hF00F, 0, 1);
    chk_all("R8");
    step(0, 0, '0, 0, 1);
    chk_all("R8");
    step(1, 1, 16'hF010, 0, 0);
    chk_all("R4");
    drain("R7");
  endtask

  task automatic t_simul();
    for (int i = 0; i < 4; i++) step(1, 0, 16'h6000 + 16'(i), 0, 0);
    for (int i = 0; i < 4; i++) begin
      step(1, 0, 16'h6100 + 16'(i), 1, 0);
      chk("R10", "pop value", 32'(dout), 32'(16'h6000 + 16'(i)));
      chk_all("R10");
    end
    drain("R10");
  endtask

  initial begin
    rst_n = 1'b0;
    conv = 0; ghost = 0; rd = 0; clr = 0; din = '0;
    m_ovf = 1'b0; m_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_order();
    t_ghost();
    t_empty_read();
    t_fill();
    t_overflow();
    t_simul();
    summary();
  end

endmodule